// File: doc/BRIEF.md
# Majority-Vote UART Receiver

This block receives asynchronous serial characters. The idle line sits high. The block samples the line on a tick that runs at 16 times the bit rate. Each bit's value is decided by a two-out-of-three vote over the samples in the middle of the bit. A character carries 8 or 9 data bits, least significant bit first, and ends with a stop bit.

When the stop bit has been voted, the whole word moves at once into a holding register, and the data-ready flag goes high. The shift path is then free to take the next character while software is still reading the held one. Status flags go with each held word: noise when any voted bit had samples that disagreed, framing error when the stop bit was low, and break when the whole frame was low.

A new word that completes while the held word is still unread sets an overrun flag and is dropped. A one-cycle read strobe releases the held word and clears all flags. Baud generation and bus decoding belong to the surrounding logic.

Top module: `uart_mv_rx`

## Requirements
- R1: After a synchronous reset, every output is 0: data, ninth bit, data ready, noise, framing error, overrun and break.
- R2: A start is accepted only on a low sample that follows a high sample seen while idle. If the start bit's vote is 1, the receiver returns to idle, delivers no word, and then accepts the next proper frame.
- R3: In 8-bit mode (`nine_bit_mode`=0), eight data bits are assembled least significant bit first into `rx_data`, and `rx_bit8` reads 0.
- R4: In 9-bit mode (`nine_bit_mode`=1), a ninth data bit follows the eighth and appears on `rx_bit8`.
- R5: Counting the 16 ticks of a bit as samples 1 to 16, each bit is decided by a majority vote of samples 7, 8 and 9. One disagreeing sample does not change the bit. Two disagreeing samples flip it.
- R6: `noise_err` is set with the held word when any voted bit of that frame had samples that were not all equal.
- R7: `frame_err` is set with the held word when the stop bit votes to 0.
- R8: A frame whose start, data and stop bits all vote 0 sets `break_det` together with `frame_err`, and holds all-zero data. The receiver then starts no new frame until the line has been seen high.
- R9: `data_ready` rises when a word is transferred. A one-cycle `rd_strobe` clears `data_ready` and every flag.
- R10: If a word completes while `data_ready` is still set and no read occurs in that cycle, `overrun_err` is set. The held word and its flags are kept, and the new word is discarded.
- R11: A read strobe issued while a second character is being shifted in clears `data_ready`. The second word then loads normally, without overrun.
- R12: While `rx_enable` is 0, no frame is received and the held word and `data_ready` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial input line, idle high |
| nine_bit_mode | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| rx_enable | input | 1 | Receiver enable |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rd_strobe | input | 1 | One-cycle read acknowledge of the held word |
| rx_data | output | 8 | Low eight bits of the held word |
| rx_bit8 | output | 1 | Ninth bit of the held word |
| data_ready | output | 1 | Held word is valid and unread |
| noise_err | output | 1 | Samples disagreed in the held frame |
| frame_err | output | 1 | Stop bit of the held frame voted low |
| overrun_err | output | 1 | A later word was lost |
| break_det | output | 1 | Held frame was an all-low break |

## Verification
The hardest case to reach is a vote that differs from most of the bit: a single sample, or two, inside the three-sample window that disagree with the other thirteen ticks of the bit. The bench builds every bit tick by tick. It holds the line for one slot per tick pulse that it generates itself, so each slot lands on a known sample number. A per-bit mask then flips exactly samples 8, or 7 and 8. The mid-frame read and the overrun case are reached by interleaving strobes between the slots of a second frame.

// File: rtl/uart_mv_pkg.sv
package uart_mv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/uart_mv_sync.sv
module uart_mv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b1;
        else     chain[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b1;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_mv_vote.sv
module uart_mv_vote (
  input  logic [2:0] samples,
  output logic       value,
  output logic       disagree
);
  always_comb begin
    value    = (samples[0] & samples[1]) | (samples[0] & samples[2]) | (samples[1] & samples[2]);
    disagree = (samples != 3'b000) && (samples != 3'b111);
  end
endmodule

// File: rtl/uart_mv_frame.sv
module uart_mv_frame
  import uart_mv_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            tick,
  input  logic            line,
  input  logic            nine,
  output logic            done,
  output logic [DATA_W:0] word,
  output logic            noise,
  output logic            ferr,
  output logic            brk
);
  localparam int CW  = $clog2(OVERSAMPLE);
  localparam int BW  = $clog2(DATA_W + 1);
  localparam int MID = OVERSAMPLE / 2;
  localparam logic [CW-1:0] SA_CNT   = CW'(MID - 2);
  localparam logic [CW-1:0] SB_CNT   = CW'(MID - 1);
  localparam logic [CW-1:0] VOTE_CNT = CW'(MID);
  localparam logic [CW-1:0] LAST_CNT = CW'(OVERSAMPLE - 1);

  rx_state_t       state;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bidx;
  logic [BW-1:0]   last_idx;
  logic            armed;
  logic            s_a, s_b;
  logic            noise_acc;
  logic [DATA_W:0] shreg;
  logic            vbit, vdis;

  uart_mv_vote u_vote (
    .samples  ({s_a, s_b, line}),
    .value    (vbit),
    .disagree (vdis)
  );

  assign last_idx = nine ? BW'(DATA_W) : BW'(DATA_W - 1);
  assign word     = shreg;

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst || !en) begin
      state     <= ST_IDLE;
      armed     <= 1'b0;
      cnt       <= '0;
      bidx      <= '0;
      s_a       <= 1'b1;
      s_b       <= 1'b1;
      noise_acc <= 1'b0;
      if (rst) begin
        shreg <= '0;
        noise <= 1'b0;
        ferr  <= 1'b0;
        brk   <= 1'b0;
      end
    end else if (tick) begin
      if (state == ST_IDLE) begin
        if (line) begin
          armed <= 1'b1;
        end else if (armed) begin
          state     <= ST_START;
          cnt       <= CW'(1);
          bidx      <= '0;
          shreg     <= '0;
          noise_acc <= 1'b0;
        end
      end else begin
        cnt <= (cnt == LAST_CNT) ? '0 : cnt + CW'(1);
        if (cnt == SA_CNT) s_a <= line;
        if (cnt == SB_CNT) s_b <= line;
        if (cnt == VOTE_CNT) begin
          case (state)
            ST_START: begin
              if (vbit) state <= ST_IDLE;
              else      noise_acc <= vdis;
            end
            ST_DATA: begin
              shreg[bidx] <= vbit;
              noise_acc   <= noise_acc | vdis;
            end
            ST_STOP: begin
              done  <= 1'b1;
              noise <= noise_acc | vdis;
              ferr  <= ~vbit;
              brk   <= ~vbit && (shreg == '0);
              armed <= vbit;
              state <= ST_IDLE;
            end
            default: ;
          endcase
        end
        if (cnt == LAST_CNT) begin
          case (state)
            ST_START: state <= ST_DATA;
            ST_DATA: begin
              if (bidx == last_idx) state <= ST_STOP;
              else                  bidx  <= bidx + BW'(1);
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/uart_mv_rx.sv
module uart_mv_rx #(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_line,
  input  logic              nine_bit_mode,
  input  logic              rx_enable,
  input  logic              tick16,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit8,
  output logic              data_ready,
  output logic              noise_err,
  output logic              frame_err,
  output logic              overrun_err,
  output logic              break_det
);
  logic            line_s;
  logic            frame_done;
  logic [DATA_W:0] frame_word;
  logic            frame_noise, frame_ferr, frame_brk;
  logic [DATA_W:0] hold_q;
  logic            still_held;

  uart_mv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rx_line),
    .dout (line_s)
  );

  uart_mv_frame #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_frame (
    .clk   (clk),
    .rst   (rst),
    .en    (rx_enable),
    .tick  (tick16),
    .line  (line_s),
    .nine  (nine_bit_mode),
    .done  (frame_done),
    .word  (frame_word),
    .noise (frame_noise),
    .ferr  (frame_ferr),
    .brk   (frame_brk)
  );

  assign still_held = data_ready & ~rd_strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q      <= '0;
      data_ready  <= 1'b0;
      noise_err   <= 1'b0;
      frame_err   <= 1'b0;
      overrun_err <= 1'b0;
      break_det   <= 1'b0;
    end else begin
      if (rd_strobe) begin
        data_ready  <= 1'b0;
        noise_err   <= 1'b0;
        frame_err   <= 1'b0;
        overrun_err <= 1'b0;
        break_det   <= 1'b0;
      end
      if (frame_done) begin
        if (still_held) begin
          overrun_err <= 1'b1;
        end else begin
          hold_q     <= frame_word;
          data_ready <= 1'b1;
          noise_err  <= frame_noise;
          frame_err  <= frame_ferr;
          break_det  <= frame_brk;
        end
      end
    end
  end

  assign rx_data = hold_q[DATA_W-1:0];
  assign rx_bit8 = hold_q[DATA_W];
endmodule

// File: rtl/uart_mv_rx_chk.sv
module uart_mv_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_enable,
  input logic              rd_strobe,
  input logic              frame_done,
  input logic [DATA_W-1:0] rx_data,
  input logic              data_ready,
  input logic              noise_err,
  input logic              frame_err,
  input logic              overrun_err,
  input logic              break_det
);
  // R9: a read with no completing word empties the holding register
  p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !frame_done) |=> !data_ready);

  // R10: a word arriving on an unread one raises overrun and keeps the old data
  p_overrun_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    (data_ready && !rd_strobe && frame_done) |=> (overrun_err && data_ready && $stable(rx_data)));

  // R8: break is only reported with a framing error on all-zero data
  p_break_frame_r8: assert property (@(posedge clk) disable iff (rst)
    break_det |-> (frame_err && data_ready && rx_data == '0));

  // R12: a disabled receiver completes no frame
  p_disabled_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !rx_enable |=> !frame_done);

  // R6: the noise flag belongs to a held word
  p_noise_held_r6: assert property (@(posedge clk) disable iff (rst)
    noise_err |-> data_ready);

  // R7: the framing flag belongs to a held word
  p_frame_held_r7: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> data_ready);
endmodule

bind uart_mv_rx uart_mv_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_enable   (rx_enable),
  .rd_strobe   (rd_strobe),
  .frame_done  (frame_done),
  .rx_data     (rx_data),
  .data_ready  (data_ready),
  .noise_err   (noise_err),
  .frame_err   (frame_err),
  .overrun_err (overrun_err),
  .break_det   (break_det)
);

// File: tb/tb_uart_mv_rx.sv
module tb_uart_mv_rx;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_line = 1'b1;
  logic       nine_bit_mode = 1'b0;
  logic       rx_enable = 1'b1;
  logic       tick16 = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit8, data_ready, noise_err, frame_err, overrun_err, break_det;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_mv_rx dut (
    .clk(clk), .rst(rst), .rx_line(rx_line), .nine_bit_mode(nine_bit_mode),
    .rx_enable(rx_enable), .tick16(tick16), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_bit8(rx_bit8), .data_ready(data_ready),
    .noise_err(noise_err), .frame_err(frame_err), .overrun_err(overrun_err),
    .break_det(break_det)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one tick slot: line set, synchronizer settles, then a tick pulse samples it
  task automatic slot(input logic v);
    rx_line = v;
    @(negedge clk);
    @(negedge clk);
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
  endtask

  task automatic send_bit(input logic v, input logic [15:0] flip);
    for (int k = 0; k < 16; k++) slot(v ^ flip[k]);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) slot(1'b1);
  endtask

  task automatic send_frame(input logic [8:0] w, input int nbits, input logic stopv,
                            input int fbit, input logic [15:0] flip);
    send_bit(1'b0, 16'h0);
    for (int i = 0; i < nbits; i++) send_bit(w[i], (i == fbit) ? flip : 16'h0);
    send_bit(stopv, 16'h0);
  endtask

  task automatic do_read();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "data", rx_data, 0);
    check("R1", "bit8", rx_bit8, 0);
    check("R1", "flags", {data_ready, noise_err, frame_err, overrun_err, break_det}, 0);
  endtask

  task automatic t_basic8();
    idle(4);
    send_frame(9'h0A5, 8, 1'b1, -1, 16'h0);
    idle(2);
    check("R3", "data", rx_data, 8'hA5);
    check("R3", "bit8", rx_bit8, 0);
    check("R9", "ready", data_ready, 1);
    check("R6", "clean flags", {noise_err, frame_err, break_det, overrun_err}, 0);
    do_read();
    check("R9", "ready after read", data_ready, 0);
  endtask

  task automatic t_nine();
    nine_bit_mode = 1'b1;
    send_frame(9'h13C, 9, 1'b1, -1, 16'h0);
    idle(2);
    check("R4", "data", rx_data, 8'h3C);
    check("R4", "bit8", rx_bit8, 1);
    do_read();
    nine_bit_mode = 1'b0;
  endtask

  task automatic t_noise();
    // sample 8 of bit 2 flipped: value kept, noise flagged
    send_frame(9'h05A, 8, 1'b1, 2, 16'h0080);
    idle(2);
    check("R5", "single glitch data", rx_data, 8'h5A);
    check("R6", "noise", noise_err, 1);
    do_read();
    check("R9", "noise cleared", noise_err, 0);
    // samples 7 and 8 of bit 0 flipped: bit becomes 1
    send_frame(9'h000, 8, 1'b1, 0, 16'h00C0);
    idle(2);
    check("R5", "double glitch data", rx_data, 8'h01);
    check("R6", "noise double", noise_err, 1);
    do_read();
    // flips outside the window change nothing
    send_frame(9'h0C3, 8, 1'b1, 4, 16'hFE3F);
    idle(2);
    check("R5", "outside window data", rx_data, 8'hC3);
    check("R6", "outside window noise", noise_err, 0);
    do_read();
  endtask

  task automatic t_frame();
    send_frame(9'h033, 8, 1'b0, -1, 16'h0);
    idle(2);
    check("R7", "ferr", frame_err, 1);
    check("R7", "break", break_det, 0);
    check("R7", "data", rx_data, 8'h33);
    do_read();
    idle(2);
  endtask

  task automatic t_break();
    send_frame(9'h000, 8, 1'b0, -1, 16'h0);
    slot(1'b0);
    slot(1'b0);
    check("R8", "break", break_det, 1);
    check("R8", "ferr", frame_err, 1);
    check("R8", "data", rx_data, 0);
    do_read();
    for (int k = 0; k < 200; k++) slot(1'b0);
    check("R8", "no restart while low", data_ready, 0);
    idle(4);
  endtask

  task automatic t_false_start();
    for (int k = 0; k < 4; k++) slot(1'b0);
    idle(40);
    check("R2", "no word", data_ready, 0);
    send_frame(9'h081, 8, 1'b1, -1, 16'h0);
    idle(2);
    check("R2", "recovered data", rx_data, 8'h81);
    check("R2", "recovered ready", data_ready, 1);
    do_read();
  endtask

  task automatic t_overrun();
    send_frame(9'h011, 8, 1'b1, -1, 16'h0);
    idle(2);
    send_frame(9'h022, 8, 1'b1, -1, 16'h0);
    idle(2);
    check("R10", "kept data", rx_data, 8'h11);
    check("R10", "overrun", overrun_err, 1);
    do_read();
    check("R10", "overrun cleared", overrun_err, 0);
  endtask

  task automatic t_double();
    logic [7:0] w;
    w = 8'h55;
    send_frame(9'h044, 8, 1'b1, -1, 16'h0);
    idle(2);
    send_bit(1'b0, 16'h0);
    for (int i = 0; i < 4; i++) send_bit(w[i], 16'h0);
    check("R11", "first held", rx_data, 8'h44);
    do_read();
    check("R11", "ready cleared mid frame", data_ready, 0);
    for (int i = 4; i < 8; i++) send_bit(w[i], 16'h0);
    send_bit(1'b1, 16'h0);
    idle(2);
    check("R11", "second data", rx_data, 8'h55);
    check("R11", "no overrun", {data_ready, overrun_err}, 2'b10);
    do_read();
  endtask

  task automatic t_disable();
    send_frame(9'h066, 8, 1'b1, -1, 16'h0);
    idle(2);
    rx_enable = 1'b0;
    send_frame(9'h077, 8, 1'b1, -1, 16'h0);
    idle(2);
    check("R12", "held data", rx_data, 8'h66);
    check("R12", "ready and overrun", {data_ready, overrun_err}, 2'b10);
    rx_enable = 1'b1;
    do_read();
    idle(4);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic8();
    t_nine();
    t_noise();
    t_frame();
    t_break();
    t_false_start();
    t_overrun();
    t_double();
    t_disable();
    finish_run();
  end
endmodule